// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address made of a segment part and an offset into a linear address. A mode input picks how the segment part is read. In real mode the 16-bit segment value is moved up four bit places and the low 16 bits of the offset are added to it. The sum is 20 bits wide and wraps inside the first mebibyte. In protected mode a selector input picks one entry of a small on-block descriptor table. The 32-bit offset is tested against that entry's limit, and the offset is added to the entry's base.

Each descriptor holds a 32-bit base, a 20-bit limit and a granularity bit. The limit gives the offset of the last byte of the segment. When the granularity bit is set, twelve one bits are appended to the limit, so it counts in 4 KiB pages. Entries are loaded through a write port. A reset marks every entry as absent. A request that uses an absent entry, or an offset beyond the limit, gives a fault instead of a valid address. Every result is registered and appears one clock after the request.

Top module: `segxl_top`

## Requirements
- R1: With `prot_mode`=0, a request gives `lin_addr` = (`seg_in`·16 + `off_in[15:0]`) mod 2^20 with bits 31:20 zero, `addr_valid`=1 and `limit_fault`=0 (segment 1200h, offset FFF0h gives 21FF0h).
- R2: A real-mode sum that carries past bit 19 drops the carry (segment FFFFh, offset 0010h gives 00000h).
- R3: With `prot_mode`=1 and an offset inside the limit, `lin_addr` = (entry base + `off_in`) mod 2^32 with `addr_valid`=1.
- R4: With granularity 0 the effective limit is the 20-bit limit zero-extended. An offset equal to it is accepted, and that value plus one faults.
- R5: With granularity 1 the effective limit is {limit, FFFh}. Base 23000000h with limit 012FFh accepts offset 012FFFFFh (giving 242FFFFFh) and faults on 01300000h.
- R6: A faulting request gives `limit_fault`=1, `addr_valid`=0 and `lin_addr`=0. The two flags are never high together.
- R7: A protected-mode request that names an entry not loaded since reset faults.
- R8: Results appear on the clock edge after the request. A cycle with `req_valid`=0 gives both flags low on the next edge and leaves `lin_addr` unchanged.
- R9: A write becomes visible to requests from the next cycle on. A request in the same cycle as a write to its entry sees the old contents. Rewriting an entry replaces all of its fields.
- R10: While `rst_n` is low, `addr_valid`, `limit_fault` and `lin_addr` are all zero.
- R11: In real mode, `off_in[31:16]` and `sel_in` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| prot_mode | input | 1 | 1 = descriptor mode, 0 = shift-and-add mode |
| seg_in | input | 16 | Segment value (real mode) |
| sel_in | input | 3 | Descriptor entry picked for translation (protected mode) |
| off_in | input | 32 | Offset; only bits 15:0 are used in real mode |
| wr_en | input | 1 | Load a descriptor entry |
| wr_idx | input | 3 | Entry to load |
| wr_base | input | 32 | Base to load |
| wr_limit | input | 20 | Limit to load |
| wr_gran | input | 1 | Granularity bit to load |
| lin_addr | output | 32 | Registered linear address |
| addr_valid | output | 1 | Registered: the address is good |
| limit_fault | output | 1 | Registered: absent entry or offset past limit |

## Verification
Every result (address, valid flag, fault flag) is due exactly one clock edge after its request is driven. A descriptor write changes results only for requests driven on a later cycle. Inputs are driven on the falling edge. The reference model works out the expected outputs at that moment, using the table contents from before any write in the same cycle. On the next falling edge, after the single rising edge, all three outputs are compared. The model then applies the write to its own table, so same-cycle write-and-read cases line up with R9.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  localparam int unsigned SX_BASE_W  = 32;
  localparam int unsigned SX_LIM_W   = 20;
  localparam int unsigned SX_GRAN_SH = 12;
  localparam int unsigned SX_SEG_W   = 16;
  localparam int unsigned SX_SEG_SH  = 4;
  localparam int unsigned SX_REAL_W  = 20;

  typedef struct packed {
    logic [SX_BASE_W-1:0] base;
    logic [SX_LIM_W-1:0]  limit;
    logic                 gran;
  } seg_desc_t;
endpackage

// File: rtl/segxl_desc_table.sv
module segxl_desc_table
  import segxl_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc,
  output logic             rd_present
);

  seg_desc_t          slot_q [ENTRIES];
  logic [ENTRIES-1:0] slot_we;
  logic [ENTRIES-1:0] pres_q;
  logic [ENTRIES-1:0] pres_d;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
      // storage carries no reset; presence bits guard it
      always_ff @(posedge clk) begin
        if (slot_we[g]) begin
          slot_q[g] <= wr_desc;
        end
      end
    end
  endgenerate

  always_comb begin
    pres_d = pres_q | slot_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
    end else begin
      pres_q <= pres_d;
    end
  end

  assign rd_desc    = slot_q[rd_idx];
  assign rd_present = pres_q[rd_idx];

  // R9: a loaded entry is present on the following cycle
  assert_write_marks_present_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_en |=> pres_q[$past(wr_idx)]
  );

endmodule

// File: rtl/segxl_real_calc.sv
module segxl_real_calc #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned OUT_W  = 32,
  localparam int unsigned REAL_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [OUT_W-1:0] addr
);

  logic [REAL_W-1:0] seg_ext;
  logic [REAL_W-1:0] off_ext;
  logic [REAL_W-1:0] sum;

  always_comb begin
    seg_ext = {seg, {SHIFT{1'b0}}};
    off_ext = REAL_W'(off[SEG_W-1:0]);
    sum     = seg_ext + off_ext;     // carry out of the top bit is dropped
    addr    = OUT_W'(sum);
  end

endmodule

// File: rtl/segxl_prot_calc.sv
module segxl_prot_calc
  import segxl_pkg::*;
#(
  parameter int unsigned OFF_W = 32,
  localparam int unsigned EXT_W = SX_LIM_W + SX_GRAN_SH
) (
  input  seg_desc_t            desc,
  input  logic                 present,
  input  logic [OFF_W-1:0]     off,
  output logic [SX_BASE_W-1:0] addr,
  output logic                 in_bounds
);

  logic [EXT_W-1:0] eff_lim;

  always_comb begin
    if (desc.gran) begin
      eff_lim = {desc.limit, {SX_GRAN_SH{1'b1}}};
    end else begin
      eff_lim = {{SX_GRAN_SH{1'b0}}, desc.limit};
    end
    in_bounds = present && (OFF_W'(eff_lim) >= off);
    addr      = desc.base + SX_BASE_W'(off);
  end

endmodule

// File: rtl/segxl_top.sv
module segxl_top
  import segxl_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned OFF_W   = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned OUT_W  = SX_BASE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 prot_mode,
  input  logic [SX_SEG_W-1:0]  seg_in,
  input  logic [IDX_W-1:0]     sel_in,
  input  logic [OFF_W-1:0]     off_in,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [SX_BASE_W-1:0] wr_base,
  input  logic [SX_LIM_W-1:0]  wr_limit,
  input  logic                 wr_gran,
  output logic [OUT_W-1:0]     lin_addr,
  output logic                 addr_valid,
  output logic                 limit_fault
);

  seg_desc_t        wr_desc;
  seg_desc_t        rd_desc;
  logic             rd_present;
  logic [OUT_W-1:0] real_addr;
  logic [OUT_W-1:0] prot_addr;
  logic             prot_ok;

  logic [OUT_W-1:0] lin_q, lin_d;
  logic             vld_q, vld_d;
  logic             flt_q, flt_d;
  logic             lin_en;

  assign wr_desc = '{base: wr_base, limit: wr_limit, gran: wr_gran};

  segxl_desc_table #(.ENTRIES(ENTRIES)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_desc    (wr_desc),
    .rd_idx     (sel_in),
    .rd_desc    (rd_desc),
    .rd_present (rd_present)
  );

  segxl_real_calc #(
    .SEG_W (SX_SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SX_SEG_SH),
    .OUT_W (OUT_W)
  ) u_real (
    .seg  (seg_in),
    .off  (off_in),
    .addr (real_addr)
  );

  segxl_prot_calc #(.OFF_W(OFF_W)) u_prot (
    .desc      (rd_desc),
    .present   (rd_present),
    .off       (off_in),
    .addr      (prot_addr),
    .in_bounds (prot_ok)
  );

  // next-state logic
  always_comb begin
    lin_en = req_valid;
    lin_d  = lin_q;
    vld_d  = 1'b0;
    flt_d  = 1'b0;
    if (req_valid) begin
      if (!prot_mode) begin
        lin_d = real_addr;
        vld_d = 1'b1;
      end else if (prot_ok) begin
        lin_d = prot_addr;
        vld_d = 1'b1;
      end else begin
        lin_d = '0;
        flt_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      vld_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      if (lin_en) begin
        lin_q <= lin_d;
      end
      vld_q <= vld_d;
      flt_q <= flt_d;
    end
  end

  assign lin_addr    = lin_q;
  assign addr_valid  = vld_q;
  assign limit_fault = flt_q;

  assert_flags_exclusive_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(addr_valid && limit_fault)
  );

  assert_fault_clears_addr_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    limit_fault |-> (lin_addr == '0)
  );

  assert_idle_quiet_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && !limit_fault && $stable(lin_addr))
  );

  assert_real_in_first_mib_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode) |=> (addr_valid && (lin_addr[OUT_W-1:SX_REAL_W] == '0))
  );

  assert_absent_entry_faults_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && prot_mode && !rd_present) |=> limit_fault
  );

endmodule

// File: tb/segxl_top_tb_top.sv
module segxl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, prot_mode, wr_en, wr_gran;
  logic [15:0] seg_in;
  logic [2:0]  sel_in, wr_idx;
  logic [31:0] off_in, wr_base;
  logic [19:0] wr_limit;
  logic [31:0] lin_addr;
  logic        addr_valid, limit_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  segxl_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
    .seg_in(seg_in), .sel_in(sel_in), .off_in(off_in), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit), .wr_gran(wr_gran),
    .lin_addr(lin_addr), .addr_valid(addr_valid), .limit_fault(limit_fault)
  );

  // behavioural reference state
  longint m_base [8];
  longint m_lim  [8];
  bit     m_gran [8];
  bit     m_pres [8];
  longint exp_addr;
  bit     exp_v, exp_f;
  string  exp_tag;
  int     n_vec = 0;
  int     n_bad = 0;

  task automatic compare();
    n_vec++;
    if (longint'(lin_addr) != exp_addr || addr_valid !== exp_v || limit_fault !== exp_f) begin
      n_bad++;
      $display("FAIL %s: got addr=%08h v=%0b f=%0b, expected addr=%08h v=%0b f=%0b",
               exp_tag, lin_addr, addr_valid, limit_fault, exp_addr[31:0], exp_v, exp_f);
    end
  endtask

  task automatic step(input bit rv, input bit pm, input logic [15:0] seg,
                      input logic [2:0] sel, input logic [31:0] off,
                      input bit we, input logic [2:0] wi, input logic [31:0] wb,
                      input logic [19:0] wl, input bit wg, input string tag);
    longint lim;
    @(negedge clk);
    compare();
    if (rv) begin
      if (!pm) begin
        exp_addr = ((longint'(seg) << 4) + (longint'(off) & 64'hFFFF)) & 64'hFFFFF;
        exp_v = 1; exp_f = 0;
      end else begin
        lim = m_gran[sel] ? ((m_lim[sel] << 12) | 64'hFFF) : m_lim[sel];
        if (!m_pres[sel] || longint'(off) > lim) begin
          exp_addr = 0; exp_v = 0; exp_f = 1;
        end else begin
          exp_addr = (m_base[sel] + longint'(off)) & 64'hFFFF_FFFF;
          exp_v = 1; exp_f = 0;
        end
      end
    end else begin
      exp_v = 0; exp_f = 0;
    end
    exp_tag = tag;
    req_valid = rv; prot_mode = pm; seg_in = seg; sel_in = sel; off_in = off;
    wr_en = we; wr_idx = wi; wr_base = wb; wr_limit = wl; wr_gran = wg;
    if (we) begin
      m_base[wi] = longint'(wb); m_lim[wi] = longint'(wl);
      m_gran[wi] = wg; m_pres[wi] = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    req_valid = 0; prot_mode = 0; seg_in = 0; sel_in = 0; off_in = 0;
    wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0; wr_gran = 0;
    for (int i = 0; i < 8; i++) m_pres[i] = 0;
    exp_addr = 0; exp_v = 0; exp_f = 0; exp_tag = "R10 reset state";
    @(negedge clk);
    compare();
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // real mode
    step(1, 0, 16'h1200, 0, 32'h0000_FFF0, 0, 0, 0, 0, 0, "R1 1200:FFF0");
    step(1, 0, 16'h1000, 0, 32'h0000_0023, 0, 0, 0, 0, 0, "R1 1000:0023");
    step(1, 0, 16'hAAF0, 0, 32'h0000_0134, 0, 0, 0, 0, 0, "R1 AAF0:0134");
    step(1, 0, 16'hFFFF, 0, 32'h0000_0010, 0, 0, 0, 0, 0, "R2 wrap to zero");
    step(1, 0, 16'hF000, 0, 32'h0000_FFFF, 0, 0, 0, 0, 0, "R2 top of window");
    step(1, 0, 16'h1000, 5, 32'hABCD_0023, 0, 0, 0, 0, 0, "R11 upper offset ignored");
    // protected mode, empty table
    step(1, 1, 0, 3, 32'h0, 0, 0, 0, 0, 0, "R7 absent entry");
    // write entry 0 while reading it in the same cycle
    step(1, 1, 0, 0, 32'h0, 1, 0, 32'h2300_0000, 20'h012FF, 0, "R9 same-cycle old content");
    step(1, 1, 0, 0, 32'h0000_12FF, 0, 0, 0, 0, 0, "R4 offset at byte limit");
    step(1, 1, 0, 0, 32'h0000_1300, 0, 0, 0, 0, 0, "R4 one past byte limit");
    step(1, 1, 0, 5, 32'h0, 1, 5, 32'h2300_0000, 20'h012FF, 1, "R7 entry 5 before write");
    step(1, 1, 0, 5, 32'h012F_FFFF, 0, 0, 0, 0, 0, "R5 offset at page limit");
    step(1, 1, 0, 5, 32'h0130_0000, 0, 0, 0, 0, 0, "R5 past page limit");
    step(0, 1, 0, 5, 32'h0000_0040, 0, 0, 0, 0, 0, "R8 idle after fault");
    step(1, 1, 0, 5, 32'h0000_0040, 1, 2, 32'hFFFF_FF00, 20'hFFFFF, 1, "R3 base plus offset");
    step(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, "R8 idle holds address");
    step(1, 1, 0, 2, 32'h0000_0200, 0, 0, 0, 0, 0, "R3 32-bit wrap");
    step(1, 1, 0, 0, 32'h0000_0001, 1, 0, 32'h2300_0000, 20'h00000, 0, "R9 before rewrite");
    step(1, 1, 0, 0, 32'h0000_0001, 0, 0, 0, 0, 0, "R9 rewritten limit");
    step(1, 1, 0, 0, 32'h0000_0000, 0, 0, 0, 0, 0, "R9 rewritten entry offset 0");
    step(1, 0, 16'h0001, 7, 32'hFFFF_0002, 0, 0, 0, 0, 0, "R11 selector ignored");
    step(1, 1, 0, 7, 32'h0, 0, 0, 0, 0, 0, "R6 absent entry flags");
    step(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, "R6 fault result");
    do_reset();
    step(1, 1, 0, 5, 32'h0, 0, 0, 0, 0, 0, "R7 reset clears entries");
    step(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, "R7 entry absent after reset");
    step(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, "R8 idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule